// File: doc/BRIEF.md
# Multi-Line Atomic Event Address Arbiter

This block decides whether an agent may start an atomic event that touches several cache lines. An agent sends one message that names up to eight line addresses. The arbiter checks each address against the lines it has already handed out. If none of them is held, the arbiter hands out the whole set at once and records it. If any address is held, the arbiter hands out nothing. In that case it reports how many agents are contending for the busiest of the conflicting lines, and software can use that figure to back off or pick other lines.

When an event finishes, the agent sends a release message naming the same addresses, and the arbiter drops them from its table. The table has a fixed number of entries. A request that cannot fit in the free entries is refused with a reserved count. The arbiter handles one message at a time and compares one address per cycle. Because of this, no two agents can ever be granted the same line.

Top module: `ae_arbiter`

## Requirements
- R1: After reset the table is empty, `req_ready` is 1, and both `rsp_valid` and `rel_err` are 0.
- R2: An acquire (`req_op`=0) whose addresses are all absent from the table is answered with `rsp_grant`=1 and `rsp_count`=0. All of its addresses are installed in the table.
- R3: A newly installed entry starts with a contention count of 0, so the first refused acquire that hits it reports 1.
- R4: An acquire that hits one or more held addresses is answered with `rsp_grant`=0 and installs nothing. Every table entry it hits has its count raised by one. The response carries the largest of those raised counts.
- R5: Entry counts saturate at 255 and never wrap.
- R6: A release (`req_op`=1) removes every named address that is held and is answered with `rsp_grant`=1 and `rsp_count`=0. Those lines can then be acquired again.
- R7: A release naming an address that is not held leaves the table unchanged for that address. It also sets `rel_err`, which stays at 1 until reset.
- R8: The table holds 32 entries. An acquire of more addresses than there are free entries is refused with `rsp_count`=255, and no entry count changes.
- R9: `req_ready` is 1 only when the arbiter is idle. Counting the cycles after the accepting edge, `rsp_valid` is a one-cycle pulse in a fixed cycle W:
  - W is 1 for a refusal because the table is too full, and for an empty set.
  - W is `req_num`+1 for a refused acquire and for a release.
  - W is 2*`req_num`+1 for a granted acquire.
- R10: Address slot i sits in `req_addr` bits [i*40 +: 40]. A `req_num` above 8 is treated as 8. `rsp_id` returns the `req_id` of the message being answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A message is offered |
| req_ready | output | 1 | Arbiter is idle and takes the message this cycle |
| req_op | input | 1 | 0 = acquire a set, 1 = release a set |
| req_id | input | 4 | Requestor identifier |
| req_num | input | 4 | Number of addresses in the set |
| req_addr | input | 320 | Eight packed cache-line addresses |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_grant | output | 1 | Set granted (acquire) or release done |
| rsp_count | output | 8 | Contention count, or 255 when the table is too full |
| rsp_id | output | 4 | Identifier of the answered message |
| rel_err | output | 1 | Sticky flag for a release of an unheld address |

## Verification
Embedded properties watch, on every cycle:
- that the response is a single-cycle pulse followed by readiness;
- that a grant never carries a nonzero count;
- that the release error flag never clears on its own;
- that every install finds a free slot and consumes exactly one.

Only the bench's scenarios can show the effects that span several messages:
- all-or-nothing installation;
- count growth and saturation across repeated refusals;
- reuse of released lines;
- the untouched counts after a full-table refusal;
- the exact response cycle for each kind of message.

The bench checks these against a behavioural table that it keeps itself.

// File: rtl/ae_arb_pkg.sv
`timescale 1ns/1ps
package ae_arb_pkg;
   typedef enum logic {
      OP_ACQ = 1'b0,
      OP_REL = 1'b1
   } op_e;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_SCAN    = 2'd1,
      ST_INSTALL = 2'd2,
      ST_RESP    = 2'd3
   } state_e;
endpackage

// File: rtl/ae_arb_table.sv
`timescale 1ns/1ps
module ae_arb_table #(
   parameter int ADDR_W = 40,
   parameter int CNT_W  = 8,
   parameter int DEPTH  = 32,
   localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int FREE_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_addr,
   input  logic              inc_en,
   input  logic              inv_en,
   input  logic              ins_en,
   output logic              hit,
   output logic [CNT_W-1:0]  hit_max,
   output logic [FREE_W-1:0] free_cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [DEPTH-1:0]  valid_q;
   logic [ADDR_W-1:0] addr_q [DEPTH];
   logic [CNT_W-1:0]  cnt_q  [DEPTH];
   logic [DEPTH-1:0]  match;
   logic [IDX_W-1:0]  first_free;
   logic              found;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign match[g] = valid_q[g] && (addr_q[g] == lk_addr);
   end

   assign hit      = |match;
   assign free_cnt = FREE_W'(DEPTH) - FREE_W'($countones(valid_q));

   always_comb begin
      hit_max    = '0;
      first_free = '0;
      found      = 1'b0;
      for (int e = 0; e < DEPTH; e++) begin
         if (match[e] && (cnt_q[e] > hit_max)) hit_max = cnt_q[e];
         if (!valid_q[e] && !found) begin
            first_free = IDX_W'(e);
            found      = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         for (int e = 0; e < DEPTH; e++) begin
            addr_q[e] <= '0;
            cnt_q[e]  <= '0;
         end
      end else begin
         for (int e = 0; e < DEPTH; e++) begin
            if (inv_en && match[e]) begin
               valid_q[e] <= 1'b0;
            end else if (inc_en && match[e]) begin
               if (cnt_q[e] != CNT_MAX) cnt_q[e] <= cnt_q[e] + 1'b1;
            end else if (ins_en && !hit && found && (first_free == IDX_W'(e))) begin
               valid_q[e] <= 1'b1;
               addr_q[e]  <= lk_addr;
               cnt_q[e]   <= '0;
            end
         end
      end
   end

   assert_install_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_en && !hit) |-> (free_cnt != '0));
   assert_install_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_en && !hit) |=> (free_cnt == $past(free_cnt) - FREE_W'(1)));
endmodule

// File: rtl/ae_arb_ctrl.sv
`timescale 1ns/1ps
module ae_arb_ctrl
   import ae_arb_pkg::*;
#(
   parameter int ADDR_W  = 40,
   parameter int MAX_SET = 8,
   parameter int ID_W    = 4,
   parameter int CNT_W   = 8,
   parameter int DEPTH   = 32,
   localparam int NUM_W  = $clog2(MAX_SET + 1),
   localparam int SEL_W  = (MAX_SET > 1) ? $clog2(MAX_SET) : 1,
   localparam int FREE_W = $clog2(DEPTH + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic                      req_op,
   input  logic [ID_W-1:0]           req_id,
   input  logic [NUM_W-1:0]          req_num,
   input  logic [MAX_SET*ADDR_W-1:0] req_addr,
   output logic                      rsp_valid,
   output logic                      rsp_grant,
   output logic [CNT_W-1:0]          rsp_count,
   output logic [ID_W-1:0]           rsp_id,
   output logic                      rel_err,
   output logic [ADDR_W-1:0]         lk_addr,
   output logic                      inc_en,
   output logic                      inv_en,
   output logic                      ins_en,
   input  logic                      hit,
   input  logic [CNT_W-1:0]          hit_max,
   input  logic [FREE_W-1:0]         free_cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   state_e            state_q;
   op_e               op_q;
   logic [NUM_W-1:0]  num_q, idx_q, num_c;
   logic [ADDR_W-1:0] addrs_q [MAX_SET];
   logic              confl_q, confl_nxt, last;
   logic [CNT_W-1:0]  max_q, max_nxt, bumped;
   logic [ID_W-1:0]   id_q;
   logic              grant_q, err_q;
   logic [CNT_W-1:0]  count_q;

   assign num_c   = (req_num > NUM_W'(MAX_SET)) ? NUM_W'(MAX_SET) : req_num;
   assign lk_addr = addrs_q[idx_q[SEL_W-1:0]];
   assign last    = (idx_q == num_q - NUM_W'(1));
   assign bumped  = (hit_max == CNT_MAX) ? CNT_MAX : hit_max + 1'b1;
   assign confl_nxt = confl_q | ((op_q == OP_ACQ) && hit);
   assign max_nxt = ((op_q == OP_ACQ) && hit && (bumped > max_q)) ? bumped : max_q;

   assign inc_en    = (state_q == ST_SCAN) && (op_q == OP_ACQ);
   assign inv_en    = (state_q == ST_SCAN) && (op_q == OP_REL);
   assign ins_en    = (state_q == ST_INSTALL);
   assign req_ready = (state_q == ST_IDLE);
   assign rsp_valid = (state_q == ST_RESP);
   assign rsp_grant = grant_q;
   assign rsp_count = count_q;
   assign rsp_id    = id_q;
   assign rel_err   = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_ACQ;
         num_q   <= '0;
         idx_q   <= '0;
         confl_q <= 1'b0;
         max_q   <= '0;
         id_q    <= '0;
         grant_q <= 1'b0;
         count_q <= '0;
         err_q   <= 1'b0;
         for (int i = 0; i < MAX_SET; i++) addrs_q[i] <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (req_valid) begin
               id_q    <= req_id;
               op_q    <= op_e'(req_op);
               num_q   <= num_c;
               idx_q   <= '0;
               confl_q <= 1'b0;
               max_q   <= '0;
               for (int i = 0; i < MAX_SET; i++)
                  addrs_q[i] <= req_addr[i*ADDR_W +: ADDR_W];
               if (num_c == '0) begin
                  grant_q <= 1'b1;
                  count_q <= '0;
                  state_q <= ST_RESP;
               end else if ((req_op == OP_ACQ) && (FREE_W'(num_c) > free_cnt)) begin
                  grant_q <= 1'b0;
                  count_q <= CNT_MAX;
                  state_q <= ST_RESP;
               end else begin
                  state_q <= ST_SCAN;
               end
            end
            ST_SCAN: begin
               confl_q <= confl_nxt;
               max_q   <= max_nxt;
               if ((op_q == OP_REL) && !hit) err_q <= 1'b1;
               if (last) begin
                  idx_q <= '0;
                  if ((op_q == OP_ACQ) && !confl_nxt) begin
                     state_q <= ST_INSTALL;
                  end else begin
                     grant_q <= (op_q == OP_REL);
                     count_q <= (op_q == OP_REL) ? '0 : max_nxt;
                     state_q <= ST_RESP;
                  end
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            ST_INSTALL: begin
               if (last) begin
                  grant_q <= 1'b1;
                  count_q <= '0;
                  state_q <= ST_RESP;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (!rsp_valid && req_ready));
   assert_grant_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_grant) |-> (rsp_count == '0));
   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rel_err |=> rel_err);
endmodule

// File: rtl/ae_arbiter.sv
`timescale 1ns/1ps
module ae_arbiter #(
   parameter int ADDR_W  = 40,
   parameter int MAX_SET = 8,
   parameter int ID_W    = 4,
   parameter int CNT_W   = 8,
   parameter int DEPTH   = 32,
   localparam int NUM_W  = $clog2(MAX_SET + 1),
   localparam int FREE_W = $clog2(DEPTH + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic                      req_op,
   input  logic [ID_W-1:0]           req_id,
   input  logic [NUM_W-1:0]          req_num,
   input  logic [MAX_SET*ADDR_W-1:0] req_addr,
   output logic                      rsp_valid,
   output logic                      rsp_grant,
   output logic [CNT_W-1:0]          rsp_count,
   output logic [ID_W-1:0]           rsp_id,
   output logic                      rel_err
);
   if (MAX_SET < 1) begin : g_bad_set
      $error("MAX_SET must be at least 1");
   end
   if (DEPTH < MAX_SET) begin : g_bad_depth
      $error("DEPTH must hold at least one full set");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end

   logic [ADDR_W-1:0] lk_addr;
   logic              inc_en, inv_en, ins_en, hit;
   logic [CNT_W-1:0]  hit_max;
   logic [FREE_W-1:0] free_cnt;

   ae_arb_ctrl #(
      .ADDR_W(ADDR_W), .MAX_SET(MAX_SET), .ID_W(ID_W), .CNT_W(CNT_W), .DEPTH(DEPTH)
   ) ctrl_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_id(req_id), .req_num(req_num), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_count(rsp_count),
      .rsp_id(rsp_id), .rel_err(rel_err),
      .lk_addr(lk_addr), .inc_en(inc_en), .inv_en(inv_en), .ins_en(ins_en),
      .hit(hit), .hit_max(hit_max), .free_cnt(free_cnt)
   );

   ae_arb_table #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(DEPTH)
   ) table_i (
      .clk(clk), .rst_n(rst_n),
      .lk_addr(lk_addr), .inc_en(inc_en), .inv_en(inv_en), .ins_en(ins_en),
      .hit(hit), .hit_max(hit_max), .free_cnt(free_cnt)
   );
endmodule

// File: tb/ae_arbiter_tb_top.sv
`timescale 1ns/1ps
module ae_arbiter_tb_top;
   localparam int AW = 40;
   localparam int MS = 8;
   localparam int IW = 4;
   localparam int CW = 8;
   localparam int DP = 32;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           req_valid = 1'b0;
   logic           req_ready;
   logic           req_op = 1'b0;
   logic [IW-1:0]  req_id = '0;
   logic [3:0]     req_num = '0;
   logic [MS*AW-1:0] req_addr = '0;
   logic           rsp_valid, rsp_grant, rel_err;
   logic [CW-1:0]  rsp_count;
   logic [IW-1:0]  rsp_id;

   always #2.5 clk = ~clk;

   ae_arbiter dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_id(req_id), .req_num(req_num), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_count(rsp_count),
      .rsp_id(rsp_id), .rel_err(rel_err)
   );

   logic [AW-1:0] abuf [MS];
   int unsigned   mdl [logic [AW-1:0]];
   bit            exp_err = 1'b0;
   int            checks = 0;
   int            errors = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic setaddr(input longint base, input int n);
      for (int i = 0; i < n; i++) abuf[i] = AW'(base + i);
   endtask

   task automatic issue(input bit op, input int id, input int n, input string tag);
      int w, c, nn;
      bit g;
      int unsigned v;
      nn = (n > MS) ? MS : n;
      c = 0; g = 1'b1;
      if (op == 1'b0) begin
         if (nn == 0) w = 1;
         else if (nn > DP - mdl.num()) begin g = 1'b0; c = 255; w = 1; end
         else begin
            for (int i = 0; i < nn; i++)
               if (mdl.exists(abuf[i])) begin
                  g = 1'b0;
                  v = mdl[abuf[i]];
                  v = (v == 255) ? 255 : v + 1;
                  mdl[abuf[i]] = v;
                  if (int'(v) > c) c = int'(v);
               end
            if (g) for (int i = 0; i < nn; i++) mdl[abuf[i]] = 0;
            w = g ? 2 * nn + 1 : nn + 1;
         end
      end else begin
         for (int i = 0; i < nn; i++)
            if (mdl.exists(abuf[i])) mdl.delete(abuf[i]);
            else exp_err = 1'b1;
         w = (nn == 0) ? 1 : nn + 1;
      end
      @(negedge clk);
      chk(req_ready == 1'b1, {tag, " R9 idle ready"}, req_ready, 1);
      req_valid = 1'b1;
      req_op    = op;
      req_id    = IW'(id);
      req_num   = 4'(n);
      for (int i = 0; i < MS; i++) req_addr[i*AW +: AW] = abuf[i];
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 1; k <= w; k++) begin
         if (k > 1) @(negedge clk);
         chk(rsp_valid == (k == w), {tag, " R9 response cycle"}, rsp_valid, (k == w));
         chk(req_ready == 1'b0, {tag, " R9 busy"}, req_ready, 0);
      end
      chk(rsp_grant == g, {tag, " grant"}, rsp_grant, g);
      chk(int'(rsp_count) == c, {tag, " count"}, rsp_count, c);
      chk(rsp_id == IW'(id), {tag, " R10 id echo"}, rsp_id, id & 15);
      chk(rel_err == exp_err, {tag, " R7 error flag"}, rel_err, exp_err);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < MS; i++) abuf[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
      chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
      chk(rel_err == 1'b0, "R1 error clear after reset", rel_err, 0);

      setaddr(1, 3);          issue(1'b0, 1, 3, "R2 grant three lines");
      abuf[0] = 5; abuf[1] = 2; issue(1'b0, 2, 2, "R3 first refusal count");
      abuf[0] = 2;            issue(1'b0, 3, 1, "R4 second refusal count");
      abuf[0] = 3; abuf[1] = 2; issue(1'b0, 4, 2, "R4 max of raised counts");
      abuf[0] = 5;            issue(1'b0, 5, 1, "R4 nothing installed on refusal");
      setaddr(10, 8);         issue(1'b0, 6, 8, "R2 grant full set");

      setaddr(1, 3);          issue(1'b1, 7, 3, "R6 release set");
      abuf[0] = 2;            issue(1'b0, 8, 1, "R6 reacquire released line");
      abuf[0] = 2;            issue(1'b0, 9, 1, "R3 reinstalled count starts at zero");

      abuf[0] = 99;           issue(1'b1, 10, 1, "R7 release of unheld line");
      abuf[0] = 99;           issue(1'b0, 11, 1, "R7 unheld release left table alone");
      abuf[0] = 99;           issue(1'b1, 12, 1, "R6 release cleanup");
      abuf[0] = 5;            issue(1'b1, 13, 1, "R7 error stays set");

      setaddr(100, 8);        issue(1'b0, 1, 8, "R2 fill part one");
      setaddr(200, 8);        issue(1'b0, 2, 8, "R2 fill part two");
      setaddr(300, 8); abuf[7] = 10; issue(1'b0, 3, 8, "R8 too full refusal");
      abuf[0] = 10;           issue(1'b0, 4, 1, "R8 counts untouched by full refusal");
      setaddr(400, 7);        issue(1'b0, 5, 7, "R8 last free entries granted");
      abuf[0] = 500;          issue(1'b0, 6, 1, "R8 full table refusal");

      setaddr(400, 7); abuf[7] = 100; issue(1'b1, 7, 12, "R10 set size clamped");
      abuf[0] = 100;          issue(1'b0, 8, 1, "R10 clamped release freed slot 7");

      for (int j = 0; j < 260; j++) begin
         abuf[0] = 10;
         issue(1'b0, j, 1, "R5 saturating count");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule